// File: doc/BRIEF.md
# Prioritized Interrupt Vector Dispatcher

This block decides which interrupt a processor should service when it executes its vector-dispatch instruction, then fetches that routine's start address from a jump table held in program memory. When a start strobe arrives, it samples three things: a software-trap pending flag, twelve maskable pending flags with their twelve enable flags, and the program counter of the dispatch instruction. It picks the best-ranked eligible source and forms the table entry address. It then reads the two-byte entry through a synchronous program-memory port and returns the assembled 16-bit jump target with a one-cycle done pulse.

The jump table sits in the same 256-byte page as the dispatch instruction. If the instruction occupies the final byte of its page, the table is taken from the following page. Each of the sixteen ranks owns a two-byte entry. The entry for rank 1 sits at page offset FEh, and each lower rank sits two bytes lower, so rank 16 sits at E0h. When nothing is eligible, the rank-16 default entry is used. Saving context, clearing flags and testing the global enable are left to the surrounding core.

Top module: `int_vector_dispatch`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `mem_req_o` are all low.
- R2: A pending software trap always selects rank 1 (entry offset FEh), whatever the maskable pending and enable flags hold.
- R3: A maskable source takes part only when both its pending bit and its enable bit are high. Source indices 0 to 4 map to ranks 3 to 7, and indices 5 to 11 map to ranks 9 to 15. Rank r uses entry offset FEh − 2·(r−1).
- R4: When several sources take part, the one with the smallest rank number wins. Ranks 2 and 8 are never selected.
- R5: With no trap and no maskable source both pending and enabled, rank 16 (offset E0h) is selected.
- R6: The table page is the high byte of the dispatch PC. When the PC's low byte is FFh, the page is that high byte plus one, modulo 256.
- R7: One cycle after the start edge, the block requests the even entry address (the high byte). One cycle later it requests the odd address (the low byte). Read data returns one cycle after each request.
- R8: Four cycles after the start edge, `done_o` is high for exactly one cycle. At that point `target_o` = {byte at the even address, byte at the odd address}.
- R9: A start strobe that arrives while `busy_o` is high is ignored. The selected entry does not change, and no extra read sequence follows.
- R10: Pending, enable, trap and PC inputs are used only in the start cycle. Changing them during the reads does not alter the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Dispatch strobe |
| dispatch_pc_i | input | 16 | Address of the dispatch instruction |
| trap_pend_i | input | 1 | Software trap pending |
| irq_pend_i | input | 12 | Maskable pending flags |
| irq_en_i | input | 12 | Maskable enable flags |
| mem_req_o | output | 1 | Program-memory read request |
| mem_addr_o | output | 16 | Program-memory read address |
| mem_data_i | input | 8 | Read data, valid one cycle after request |
| busy_o | output | 1 | Dispatch in progress |
| done_o | output | 1 | One-cycle target-valid pulse |
| target_o | output | 16 | Assembled jump target |

## Verification
Every single source is tried in turn, with its enable set and then cleared. This separates the rank mapping from the enable gating. Every pair of sources, the trap included, is then raised together, which exposes any priority inversion between neighbouring or distant ranks. The all-pending-none-enabled and all-quiet cases confirm the default entry. Dispatch PCs across ordinary addresses, page-final addresses and FFFFh separate the page roll, and its wrap, from the plain page. A disturbed run re-strobes start and flips the flags during the reads, which catches late sampling.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_SRC   = 12;
    localparam int NUM_RANKS = 16;
    localparam int RANK_W    = $clog2(NUM_RANKS);
    // maskable sources below this index sit just under the trap rank
    localparam int FIRST_GROUP = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_CAPTURE
    } disp_state_t;

    typedef struct packed {
        disp_state_t          state;
        logic [RANK_W-1:0]    rank;
        logic [ADDR_W-1:0]    entry_addr;
        logic [BYTE_W-1:0]    hi_byte;
        logic [2*BYTE_W-1:0]  target;
        logic                 done;
    } disp_regs_t;

    // zero-based rank slot owned by maskable source i (slots 1 and 7 reserved)
    function automatic int src_slot(input int i);
        return (i < FIRST_GROUP) ? i + 2 : i + 3;
    endfunction
endpackage

// File: rtl/ivd_rank_arbiter.sv
module ivd_rank_arbiter
    import ivd_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int N_RANKS = NUM_RANKS
) (
    input  logic                        trap_pend_i,
    input  logic [N_SRC-1:0]            pend_i,
    input  logic [N_SRC-1:0]            en_i,
    output logic [$clog2(N_RANKS)-1:0]  win_slot_o
);
    localparam int SW = $clog2(N_RANKS);

    logic [N_RANKS-1:0] req;

    // slot 0: trap, no enable gating; last slot: default, always requesting
    assign req[0]         = trap_pend_i;
    assign req[N_RANKS-1] = 1'b1;

    generate
        for (genvar s = 1; s < N_RANKS - 1; s++) begin : g_slot
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int i = 0; i < N_SRC; i++) begin
                    if (src_slot(i) == s) hit = hit | (pend_i[i] & en_i[i]);
                end
            end
            assign req[s] = hit;
        end
    endgenerate

    always_comb begin
        win_slot_o = SW'(N_RANKS - 1);
        for (int r = N_RANKS - 1; r >= 0; r--) begin
            if (req[r]) win_slot_o = SW'(r);
        end
    end
endmodule

// File: rtl/ivd_table_addr.sv
module ivd_table_addr
    import ivd_pkg::*;
#(
    parameter logic [7:0] TOP_OFFSET = 8'hFE
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [RANK_W-1:0] slot_i,
    output logic [ADDR_W-1:0] entry_addr_o
);
    logic       page_roll;
    logic [7:0] page;
    logic [7:0] offset;

    always_comb begin
        page_roll    = (pc_i[7:0] == 8'hFF);
        page         = pc_i[ADDR_W-1:8] + {7'd0, page_roll};
        offset       = TOP_OFFSET - {3'd0, slot_i, 1'b0};
        entry_addr_o = {page, offset};
    end
endmodule

// File: rtl/int_vector_dispatch.sv
module int_vector_dispatch
    import ivd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    dispatch_pc_i,
    input  logic                 trap_pend_i,
    input  logic [NUM_SRC-1:0]   irq_pend_i,
    input  logic [NUM_SRC-1:0]   irq_en_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic [BYTE_W-1:0]    mem_data_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2*BYTE_W-1:0]  target_o
);
    logic [RANK_W-1:0] win_slot;
    logic [ADDR_W-1:0] calc_addr;
    disp_regs_t        cur_q, nxt_d;

    ivd_rank_arbiter #(.N_SRC(NUM_SRC), .N_RANKS(NUM_RANKS)) u_arb (
        .trap_pend_i (trap_pend_i),
        .pend_i      (irq_pend_i),
        .en_i        (irq_en_i),
        .win_slot_o  (win_slot)
    );

    ivd_table_addr #(.TOP_OFFSET(8'hFE)) u_addr (
        .pc_i         (dispatch_pc_i),
        .slot_i       (win_slot),
        .entry_addr_o (calc_addr)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.state      = ST_RD_HI;
                    nxt_d.rank       = win_slot;
                    nxt_d.entry_addr = calc_addr;
                end
            end
            ST_RD_HI:   nxt_d.state = ST_RD_LO;
            ST_RD_LO: begin
                nxt_d.hi_byte = mem_data_i;
                nxt_d.state   = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                nxt_d.target = {cur_q.hi_byte, mem_data_i};
                nxt_d.done   = 1'b1;
                nxt_d.state  = ST_IDLE;
            end
            default:    nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mem_req_o  = (cur_q.state == ST_RD_HI) || (cur_q.state == ST_RD_LO);
    assign mem_addr_o = {cur_q.entry_addr[ADDR_W-1:1], cur_q.state == ST_RD_LO};
    assign busy_o     = (cur_q.state != ST_IDLE);
    assign done_o     = cur_q.done;
    assign target_o   = cur_q.target;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !done_o && !mem_req_o);

    // R2
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && trap_pend_i) |=> (cur_q.entry_addr[7:0] == 8'hFE));

    // R4
    no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cur_q.rank != RANK_W'(1)) && (cur_q.rank != RANK_W'(7)));

    // R5
    default_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !trap_pend_i && ((irq_pend_i & irq_en_i) == '0))
        |=> (cur_q.entry_addr[7:0] == 8'hE0));

    // R7
    hi_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (mem_req_o && !mem_addr_o[0]));

    // R7
    lo_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_addr_o[0]) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 16'd1));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(cur_q.entry_addr));
endmodule

// File: tb/int_vector_dispatch_tb.sv
module int_vector_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] dispatch_pc_i = '0;
    logic        trap_pend_i = 1'b0;
    logic [11:0] irq_pend_i = '0;
    logic [11:0] irq_en_i = '0;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_i = '0;
    logic        busy_o, done_o;
    logic [15:0] target_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    int_vector_dispatch u_dut (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_req_o) mem_data_i <= mem_byte(mem_addr_o);

    function automatic int exp_rank(input logic t, input logic [11:0] p, input logic [11:0] e);
        if (t) return 1;
        for (int i = 0; i < 12; i++) if (p[i] & e[i]) return (i < 5) ? i + 3 : i + 4;
        return 16;
    endfunction

    function automatic logic [15:0] exp_entry(input logic [15:0] pc, input int rank);
        logic [7:0] pg;
        pg = pc[15:8] + ((pc[7:0] == 8'hFF) ? 8'd1 : 8'd0);
        return {pg, 8'(254 - 2 * (rank - 1))};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dispatch(input logic t, input logic [11:0] p, input logic [11:0] e,
                            input logic [15:0] pc, input bit disturb, input string tag);
        logic [15:0] ea;
        logic [15:0] et;
        ea = exp_entry(pc, exp_rank(t, p, e));
        et = {mem_byte(ea), mem_byte(ea + 16'd1)};
        @(negedge clk);
        trap_pend_i = t; irq_pend_i = p; irq_en_i = e; dispatch_pc_i = pc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o && busy_o && mem_addr_o == ea, {tag, " R7 hi addr"}, {16'd0, mem_addr_o}, {16'd0, ea});
        if (disturb) begin
            // R9 R10: restrobe and flip inputs mid-read
            start_i = 1'b1; trap_pend_i = ~t; irq_pend_i = ~p; irq_en_i = ~e;
            dispatch_pc_i = pc ^ 16'h5A5A;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o && mem_addr_o == ea + 16'd1, {tag, " R7 lo addr"}, {16'd0, mem_addr_o}, {16'd0, ea + 16'd1});
        @(negedge clk);
        chk(!done_o && !mem_req_o, {tag, " R8 early done"}, {30'd0, done_o, mem_req_o}, 32'd0);
        @(negedge clk);
        chk(done_o && target_o == et, {tag, " R8 target"}, {15'd0, done_o, target_o}, {15'd0, 1'b1, et});
        @(negedge clk);
        chk(!done_o && !busy_o && !mem_req_o, {tag, " R9 single pulse/no rerun"},
            {29'd0, done_o, busy_o, mem_req_o}, 32'd0);
    endtask

    logic [15:0] pcs [6] = '{16'h0123, 16'h03FF, 16'h7FFE, 16'hFFFF, 16'h1200, 16'hA5FF};

    initial begin
        int n;
        n = 0;
        repeat (2) @(negedge clk);
        // R1
        chk(!done_o && !busy_o && !mem_req_o, "R1 reset", {29'd0, done_o, busy_o, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !busy_o && !mem_req_o, "R1 after release", {29'd0, done_o, busy_o, mem_req_o}, 32'd0);

        // R3 single sources, enabled then masked (R5 when masked)
        for (int i = 0; i < 12; i++) begin
            dispatch(1'b0, 12'(1 << i), 12'(1 << i), pcs[n % 6], 1'b0, "R3 single"); n++;
            dispatch(1'b0, 12'(1 << i), ~12'(1 << i), pcs[n % 6], 1'b0, "R3 masked"); n++;
        end
        // R2 trap with everything else active
        dispatch(1'b1, 12'hFFF, 12'hFFF, 16'h2233, 1'b0, "R2 trap");
        dispatch(1'b1, 12'h000, 12'h000, 16'h44FF, 1'b0, "R2 trap alone");
        // R5 nothing eligible
        dispatch(1'b0, 12'hFFF, 12'h000, 16'h0050, 1'b0, "R5 none enabled");
        dispatch(1'b0, 12'h000, 12'hFFF, 16'hFFFF, 1'b0, "R5 none pending");
        // R4 all pairs, R6 via PC list
        for (int a = 0; a < 13; a++) begin
            for (int b = a + 1; b < 13; b++) begin
                logic        t;
                logic [11:0] m;
                t = (b == 12);
                m = 12'(1 << a) | (t ? 12'd0 : 12'(1 << b));
                dispatch(t, m, 12'hFFF, pcs[n % 6], 1'b0, "R4 pair"); n++;
            end
        end
        // R6 page boundary cases
        dispatch(1'b0, 12'h001, 12'h001, 16'h00FE, 1'b0, "R6 no roll");
        dispatch(1'b0, 12'h001, 12'h001, 16'h00FF, 1'b0, "R6 roll");
        // R9 R10 disturbance during reads
        dispatch(1'b0, 12'h020, 12'h020, 16'h31FF, 1'b1, "R10 disturb");
        dispatch(1'b0, 12'h000, 12'h000, 16'h0F10, 1'b1, "R9 disturb");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule